// File: doc/BRIEF.md
# Configuration Window Address Decoder

This block sits between a host memory bus and a set of per-function configuration register files. The host programs a window with a base address and a byte size. Each host access that falls inside the window has the base subtracted from its address. The remaining offset is split into a bus number, a device slot, a function number and a register offset. These fields go out on the device side together with the access width and any write data.

The device side answers in the cycle after it is presented, through a single present flag and a read value. When no function answers, a read returns all ones for the width of the access, and a write is dropped. Accesses that miss the window, or arrive while no window is mapped, produce no device-side request, and their reads also return all ones. Window size is checked on each update. A size that is not a power of two, or that falls outside 1 MiB to 256 MiB, sets a sticky error flag and leaves the window unmapped.

Top module: `cfg_window_decoder`

## Requirements
- R1: During and right after reset the window is unmapped, `map_base` is all ones, `cfg_err` is 0, and neither `rsp_valid` nor `dev_req_valid` is asserted.
- R2: For a hit, the offset is `req_addr - map_base`. Offset bits 11:0 appear on `dev_offset`, bits 14:12 on `dev_func`, bits 19:15 on `dev_slot`, and bits 28:20 on `dev_bus`.
- R3: An access is a hit only when `map_base <= req_addr < map_base + size`, compared without 32-bit wraparound. Only hits raise `dev_req_valid`.
- R4: While unmapped, `map_base` reads all ones and no address is decoded. `dev_req_valid` stays low whatever the request.
- R5: A read that misses the window, or hits a function whose `dev_present` is low, returns 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1 and 2. Size code 3 is handled as code 2.
- R6: A read that hits a present function returns `dev_rdata` masked to the access width (size code 0 keeps bits 7:0, code 1 keeps bits 15:0, codes 2 and 3 keep all 32), with zeros above.
- R7: Hit writes are forwarded with `dev_write` high, the normalised size code on `dev_size` (3 becomes 2) and `req_wdata` on `dev_wdata`. Every write answers with `rsp_rdata` zero, whether the target is present or not.
- R8: An update with `cfg_enable` high maps the window only if `cfg_size` is a power of two from 2^20 to 2^28. Otherwise `cfg_err` is set and stays set until reset, and the window stays unmapped.
- R9: Every update first unmaps the window. An update with `cfg_enable` low leaves it unmapped. A request in the same cycle as an update is decoded against the window in force before the update.
- R10: Each accepted request raises `dev_req_valid` (hits only) in the next cycle and `rsp_valid` one cycle after that. `rsp_rdata` is zero when `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_update | input | 1 | Apply a new window setting this cycle |
| cfg_enable | input | 1 | Map the window on this update |
| cfg_base | input | 32 | New window base address |
| cfg_size | input | 32 | New window size in bytes |
| map_valid | output | 1 | A window is currently mapped |
| map_base | output | 32 | Current base, all ones while unmapped |
| cfg_err | output | 1 | Sticky rejected-size flag |
| req_valid | input | 1 | Host request this cycle |
| req_write | input | 1 | Host request is a write |
| req_addr | input | 32 | Host byte address |
| req_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for a request accepted two cycles earlier |
| rsp_rdata | output | 32 | Read data, zero for writes |
| dev_req_valid | output | 1 | Decoded request toward the functions |
| dev_write | output | 1 | Decoded request is a write |
| dev_bus | output | 9 | Bus number field |
| dev_slot | output | 5 | Device slot field |
| dev_func | output | 3 | Function number field |
| dev_offset | output | 12 | Register offset within the function |
| dev_size | output | 2 | Normalised width code (never 3) |
| dev_wdata | output | 32 | Write data toward the function |
| dev_present | input | 1 | Addressed function exists, same cycle as dev_req_valid |
| dev_rdata | input | 32 | Read value from the function, same cycle as dev_req_valid |

## Verification
A request driven before clock edge k shows its decoded fields on the device side after edge k. Its response appears after edge k+1. A window update applied at edge k changes `map_valid`, `map_base` and `cfg_err` after that same edge. The bench's reference model steps once per rising edge in that order. It first turns the previous cycle's device expectation into a response expectation, then decodes the current inputs against the model window, then applies any update. Every output is compared with the model at the following falling edge, so each result is sampled in the cycle it is due.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int REG_W   = 12;
    localparam int FN_W    = 3;
    localparam int SLOT_W  = 5;
    localparam int BUS_W   = 9;
    localparam int FN_LSB   = REG_W;
    localparam int SLOT_LSB = FN_LSB + FN_W;
    localparam int BUS_LSB  = SLOT_LSB + SLOT_W;
    localparam int OFFS_W   = BUS_LSB + BUS_W;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [BUS_W-1:0]  bus;
        logic [SLOT_W-1:0] slot;
        logic [FN_W-1:0]   func;
        logic [REG_W-1:0]  offs;
    } cfg_target_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic              write;
        acc_size_e         size;
        cfg_target_t       tgt;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    function automatic logic [DATA_W-1:0] lane_mask(input acc_size_e s);
        logic [DATA_W-1:0] m;
        case (s)
            ACC_BYTE: m = {{(DATA_W-8){1'b0}}, 8'hFF};
            ACC_HALF: m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default:  m = '1;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/cfgw_map_ctrl.sv
module cfgw_map_ctrl
    import cfgw_pkg::*;
#(
    parameter int MIN_LOG = 20,
    parameter int MAX_LOG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              en,
    input  logic [ADDR_W-1:0] new_base,
    input  logic [ADDR_W-1:0] new_size,
    output logic              mapped,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W:0]   limit,
    output logic              err
);
    localparam int AW1 = ADDR_W + 1;
    localparam logic [ADDR_W:0] SZ_MIN = AW1'(1) << MIN_LOG;
    localparam logic [ADDR_W:0] SZ_MAX = AW1'(1) << MAX_LOG;

    typedef struct packed {
        logic              mapped;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   limit;
        logic              err;
    } map_state_t;

    localparam map_state_t MAP_RESET = '{mapped: 1'b0, base: '1, limit: '0, err: 1'b0};

    map_state_t st_d, st_q;
    logic [ADDR_W:0] size_ext;
    logic            size_ok;

    always_comb begin
        size_ext = {1'b0, new_size};
        size_ok  = $onehot(new_size) && (size_ext >= SZ_MIN) && (size_ext <= SZ_MAX);
        st_d     = st_q;
        if (upd) begin
            st_d.mapped = 1'b0;
            st_d.base   = '1;
            st_d.limit  = '0;
            if (en) begin
                if (size_ok) begin
                    st_d.mapped = 1'b1;
                    st_d.base   = new_base;
                    st_d.limit  = {1'b0, new_base} + size_ext;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= MAP_RESET;
        else        st_q <= st_d;
    end

    assign mapped = st_q.mapped;
    assign base   = st_q.base;
    assign limit  = st_q.limit;
    assign err    = st_q.err;

    AST_MAP_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> ($onehot(limit - {1'b0, base}) && ((limit - {1'b0, base}) >= SZ_MIN)
                    && ((limit - {1'b0, base}) <= SZ_MAX)));  // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);  // R8
    AST_UNMAP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !en) |=> (!mapped && (base == '1)));  // R9
endmodule

// File: rtl/cfgw_addr_decode.sv
module cfgw_addr_decode
    import cfgw_pkg::*;
(
    input  logic              mapped,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   limit,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output cfg_target_t       tgt
);
    logic [OFFS_W-1:0] offs;

    always_comb begin
        offs     = addr[OFFS_W-1:0] - base[OFFS_W-1:0];
        hit      = mapped && (addr >= base) && ({1'b0, addr} < limit);
        tgt.offs = offs[REG_W-1:0];
        tgt.func = offs[FN_LSB +: FN_W];
        tgt.slot = offs[SLOT_LSB +: SLOT_W];
        tgt.bus  = offs[BUS_LSB +: BUS_W];
    end
endmodule

// File: rtl/cfgw_req_stage.sv
module cfgw_req_stage
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_hit,
    input  logic              in_write,
    input  acc_size_e         in_size,
    input  cfg_target_t       in_tgt,
    input  logic [DATA_W-1:0] in_wdata,
    output cfg_req_t          stage
);
    cfg_req_t st_d, st_q;

    always_comb begin
        st_d.valid = in_valid;
        st_d.hit   = in_valid && in_hit;
        st_d.write = in_write;
        st_d.size  = (in_size == ACC_RSVD) ? ACC_WORD : in_size;
        st_d.tgt   = in_tgt;
        st_d.wdata = in_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage = st_q;

    AST_RSVD_AS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == ACC_RSVD) |=> (stage.size == ACC_WORD));  // R5
endmodule

// File: rtl/cfgw_rsp_stage.sv
module cfgw_rsp_stage
    import cfgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_req_t          stage,
    input  logic              present,
    input  logic [DATA_W-1:0] rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t rsp_d, rsp_q;
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask        = lane_mask(stage.size);
        rsp_d.valid = stage.valid;
        rsp_d.data  = '0;
        if (stage.valid && !stage.write) begin
            if (stage.hit && present) rsp_d.data = rdata & mask;
            else                      rsp_d.data = mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    AST_ABSENT_BYTE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (stage.valid && !stage.write && !(stage.hit && present) && stage.size == ACC_BYTE)
        |=> (rsp_rdata == {{(DATA_W-8){1'b0}}, 8'hFF}));  // R5
    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (stage.valid && stage.write) |=> (rsp_valid && rsp_rdata == '0));  // R7
endmodule

// File: rtl/cfg_window_decoder.sv
module cfg_window_decoder
    import cfgw_pkg::*;
#(
    parameter int MIN_LOG = 20,
    parameter int MAX_LOG = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_update,
    input  logic              cfg_enable,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_size,
    output logic              map_valid,
    output logic [ADDR_W-1:0] map_base,
    output logic              cfg_err,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dev_req_valid,
    output logic              dev_write,
    output logic [BUS_W-1:0]  dev_bus,
    output logic [SLOT_W-1:0] dev_slot,
    output logic [FN_W-1:0]   dev_func,
    output logic [REG_W-1:0]  dev_offset,
    output logic [1:0]        dev_size,
    output logic [DATA_W-1:0] dev_wdata,
    input  logic              dev_present,
    input  logic [DATA_W-1:0] dev_rdata
);
    logic            win_mapped;
    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W:0]   win_limit;
    logic            dec_hit;
    cfg_target_t     dec_tgt;
    cfg_req_t        stage;

    cfgw_map_ctrl #(.MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_map (
        .clk(clk), .rst_n(rst_n), .upd(cfg_update), .en(cfg_enable),
        .new_base(cfg_base), .new_size(cfg_size),
        .mapped(win_mapped), .base(win_base), .limit(win_limit), .err(cfg_err)
    );

    cfgw_addr_decode u_dec (
        .mapped(win_mapped), .base(win_base), .limit(win_limit),
        .addr(req_addr), .hit(dec_hit), .tgt(dec_tgt)
    );

    cfgw_req_stage u_req (
        .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_hit(dec_hit),
        .in_write(req_write), .in_size(acc_size_e'(req_size)), .in_tgt(dec_tgt),
        .in_wdata(req_wdata), .stage(stage)
    );

    cfgw_rsp_stage u_rsp (
        .clk(clk), .rst_n(rst_n), .stage(stage), .present(dev_present),
        .rdata(dev_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    assign map_valid     = win_mapped;
    assign map_base      = win_base;
    assign dev_req_valid = stage.hit;
    assign dev_write     = stage.write;
    assign dev_bus       = stage.tgt.bus;
    assign dev_slot      = stage.tgt.slot;
    assign dev_func      = stage.tgt.func;
    assign dev_offset    = stage.tgt.offs;
    assign dev_size      = stage.size;
    assign dev_wdata     = stage.wdata;

    AST_NO_DECODE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req_valid |-> $past(map_valid));  // R4
    AST_DEV_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req_valid |-> $past(req_valid));  // R3
    AST_RSP_FOLLOWS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        dev_req_valid |=> rsp_valid);  // R10
endmodule

// File: tb/tb_cfg_window_decoder.sv
module tb_cfg_window_decoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_update = 0, cfg_enable = 0;
    logic [31:0] cfg_base = 0, cfg_size = 0;
    logic map_valid, cfg_err;
    logic [31:0] map_base;
    logic req_valid = 0, req_write = 0;
    logic [31:0] req_addr = 0, req_wdata = 0;
    logic [1:0] req_size = 0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic dev_req_valid, dev_write;
    logic [8:0] dev_bus;
    logic [4:0] dev_slot;
    logic [2:0] dev_func;
    logic [11:0] dev_offset;
    logic [1:0] dev_size;
    logic [31:0] dev_wdata;
    logic dev_present;
    logic [31:0] dev_rdata;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cfg_window_decoder dut (.*);

    function automatic bit fn_here(input logic [4:0] s, input logic [2:0] f);
        return (f != 3'd7) && (s < 5'd24);
    endfunction
    function automatic logic [31:0] fn_value(input logic [8:0] b, input logic [4:0] s,
                                             input logic [2:0] f, input logic [11:0] o);
        return {b, s, f, o, 3'b101};
    endfunction
    function automatic logic [31:0] width_ones(input logic [1:0] z);
        return (z == 2'd0) ? 32'hFF : (z == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction
    function automatic bit legal_size(input logic [31:0] z);
        longint v = longint'({32'b0, z});
        return (v != 0) && ((v & (v - 1)) == 0) && (v >= 64'h10_0000) && (v <= 64'h1000_0000);
    endfunction

    always_comb begin
        dev_present = dev_req_valid && fn_here(dev_slot, dev_func);
        dev_rdata   = fn_value(dev_bus, dev_slot, dev_func, dev_offset);
    end

    // Reference model state
    bit m_map, m_err;
    longint m_base, m_lim;
    bit ed_v, ed_w, ed_hit;
    logic [1:0] ed_sz;
    logic [31:0] ed_d;
    logic [8:0] ed_bus;
    logic [4:0] ed_slot;
    logic [2:0] ed_fn;
    logic [11:0] ed_off;
    bit er_v;
    logic [31:0] er_d;
    string er_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_map = 0; m_err = 0; m_base = 64'hFFFF_FFFF; m_lim = 0;
            ed_v = 0; ed_hit = 0; er_v = 0; er_d = 0; er_tag = "R10";
        end else begin
            longint a, off;
            er_v = ed_v; er_d = 0; er_tag = "R7 write rsp";
            if (ed_v && !ed_w) begin
                if (ed_hit && fn_here(ed_slot, ed_fn)) begin
                    er_d = fn_value(ed_bus, ed_slot, ed_fn, ed_off) & width_ones(ed_sz);
                    er_tag = "R6 present read";
                end else begin
                    er_d = width_ones(ed_sz);
                    er_tag = "R5 absent read";
                end
            end
            a = longint'({32'b0, req_addr});
            off = a - m_base;
            ed_v = req_valid; ed_w = req_write; ed_d = req_wdata;
            ed_sz = (req_size == 2'd3) ? 2'd2 : req_size;
            ed_hit = req_valid && m_map && (a >= m_base) && (a < m_lim);
            ed_off = off[11:0]; ed_fn = off[14:12]; ed_slot = off[19:15]; ed_bus = off[28:20];
            if (cfg_update) begin
                m_map = 0; m_base = 64'hFFFF_FFFF; m_lim = 0;
                if (cfg_enable) begin
                    if (legal_size(cfg_size)) begin
                        m_map = 1;
                        m_base = longint'({32'b0, cfg_base});
                        m_lim = m_base + longint'({32'b0, cfg_size});
                    end else m_err = 1;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 dev_req_valid", 64'(dev_req_valid), 64'(ed_v && ed_hit));
            if (ed_v && ed_hit) begin
                chk("R2 decoded fields", 64'({dev_bus, dev_slot, dev_func, dev_offset}),
                    64'({ed_bus, ed_slot, ed_fn, ed_off}));
                chk("R7 write/size/data", 64'({dev_write, dev_size, dev_wdata}),
                    64'({ed_w, ed_sz, ed_d}));
            end
            chk("R10 rsp_valid", 64'(rsp_valid), 64'(er_v));
            chk(er_v ? er_tag : "R10 idle rdata", 64'(rsp_rdata), 64'(er_d));
            chk("R9 map_valid", 64'(map_valid), 64'(m_map));
            chk("R4 map_base", 64'(map_base), 64'(m_base[31:0]));
            chk("R8 cfg_err", 64'(cfg_err), 64'(m_err));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask
    task automatic access(input bit w, input logic [31:0] a, input logic [1:0] z, input logic [31:0] d);
        req_valid = 1; req_write = w; req_addr = a; req_size = z; req_wdata = d;
        step();
        req_valid = 0;
    endtask
    task automatic window(input bit en, input logic [31:0] b, input logic [31:0] z);
        cfg_update = 1; cfg_enable = en; cfg_base = b; cfg_size = z;
        step();
        cfg_update = 0;
    endtask
    function automatic logic [31:0] at(input logic [31:0] b, input int bus, input int s,
                                       input int f, input int o);
        return b + 32'((bus << 20) | (s << 15) | (f << 12) | o);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1 map_valid", 64'(map_valid), 0);
        chk("R1 map_base", 64'(map_base), 64'hFFFF_FFFF);
        chk("R1 cfg_err", 64'(cfg_err), 0);
        chk("R1 rsp/dev idle", 64'({rsp_valid, dev_req_valid}), 0);
        #1 rst_n = 1;
        // R4: unmapped, nothing decoded
        access(0, 32'h0000_1000, 2'd2, 0);
        access(0, 32'hFFFF_FFFF, 2'd0, 0);
        step(); step();
        // R8: rejected sizes
        window(1, 32'h4000_0000, 32'h0030_0000);
        window(1, 32'h4000_0000, 32'h0008_0000);
        window(1, 32'h4000_0000, 32'h2000_0000);
        window(1, 32'h4000_0000, 32'h0);
        access(0, 32'h4000_0000, 2'd2, 0);
        // R8: largest legal size
        window(1, 32'h4000_0000, 32'h1000_0000);
        access(0, at(32'h4000_0000, 1, 2, 1, 12'h10), 2'd2, 0);   // R6 present
        access(0, at(32'h4000_0000, 1, 2, 1, 12'h13), 2'd0, 0);   // R6 byte
        access(0, at(32'h4000_0000, 1, 2, 1, 12'h22), 2'd1, 0);   // R6 half
        access(0, at(32'h4000_0000, 3, 4, 7, 12'h4), 2'd0, 0);    // R5 absent
        access(0, at(32'h4000_0000, 3, 4, 7, 12'h4), 2'd1, 0);
        access(0, at(32'h4000_0000, 3, 4, 7, 12'h4), 2'd2, 0);
        access(0, at(32'h4000_0000, 3, 4, 7, 12'h4), 2'd3, 0);
        access(0, at(32'h4000_0000, 0, 5, 0, 12'h8), 2'd3, 0);    // R6 size 3
        access(0, 32'h4FFF_FFFF, 2'd2, 0);                        // R3 last byte
        access(0, 32'h5000_0000, 2'd2, 0);                        // R3 one past
        access(0, 32'h3FFF_FFFF, 2'd0, 0);                        // R3 one before
        access(1, at(32'h4000_0000, 2, 1, 0, 12'h40), 2'd2, 32'hDEAD_BEEF); // R7
        access(1, at(32'h4000_0000, 2, 30, 0, 12'h40), 2'd3, 32'h1234_5678); // R7 absent
        access(1, 32'h6000_0000, 2'd1, 32'hAAAA);                  // R7 miss
        // R9: request in the same cycle as an update uses the old window
        req_valid = 1; req_write = 0; req_addr = at(32'h4000_0000, 1, 1, 1, 0); req_size = 2'd2;
        window(1, 32'hFFF0_0000, 32'h0010_0000);
        req_valid = 0;
        access(0, 32'h4000_0000, 2'd2, 0);
        access(0, 32'hFFF0_0000, 2'd2, 0);
        access(0, 32'hFFFF_FFFF, 2'd0, 0);
        access(0, 32'hFFEF_FFFF, 2'd0, 0);
        // R9: disable unmaps; R8 flag persists
        window(0, 32'h1000_0000, 32'h0010_0000);
        access(0, 32'h1000_0000, 2'd2, 0);
        step(); step();
        // Mixed traffic with occasional window changes
        for (int i = 0; i < 600; i++) begin
            if (i % 97 == 5) begin
                logic [31:0] b = $urandom & 32'hFFF0_0000;
                int lg = 19 + ($urandom % 11);
                window(($urandom % 5) != 0, b, 32'h1 << lg);
            end
            if ($urandom % 4 != 0) begin
                logic [31:0] a = map_base + ($urandom % 32'h0040_0000) - 32'h0002_0000;
                if ($urandom % 8 == 0) a = $urandom;
                access($urandom % 3 == 0, a, 2'($urandom), $urandom);
            end else step();
        end
        step(); step(); step();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule